// File: doc/BRIEF.md
# Key-Guarded Watchdog Register Front End

This block holds the programmable state of a two-stage watchdog timer. It sits between a simple bus access interface and the timer core. It has two register paths. The first is a 16-byte memory window that takes byte, halfword and word writes. It holds the two stage preload values and a reload/status location. The second is a configuration path with a 16-bit setup register and an 8-bit lock register. All outputs go straight to the timer core: the preload values, the enable, free-run and lock bits, the reboot enable, the clock-scale select, the interrupt type, a one-cycle kick pulse and the previous-reboot flag.

Every write into the memory window that changes state is guarded by a key pair. Software writes the value 0x80 to offset 0xC, then 0x86 to offset 0xC. Only after that does the next window write take effect, and each key pair authorises exactly one write. The lock register has a write-once lock bit. Once it is set, the enable and free-run bits are frozen until reset.

Top module: `wdt_regfront`

## Requirements
- R1: A window write to offset 0xC whose width-masked value is 0x80 arms the guard. A following write to offset 0xC with value 0x86 while armed opens it. This works at byte, halfword or word width (size code 0 = byte, 1 = halfword, 2 = word). A key value at any other offset does not arm the guard.
- R2: While open, the next window write that is not a key write is carried out, and the guard then closes. Window writes made while the guard is closed or only armed change nothing.
- R3: An authorised word write to offset 0x0 loads the stage-1 preload from data bits [19:0]. An authorised word write to offset 0x4 loads the stage-2 preload from data bits [19:0]. Both preloads reset to 0xFFFFF.
- R4: An authorised halfword write to offset 0xC with data bit 8 set drives `kick` high for exactly one cycle. This happens in the cycle after the write edge.
- R5: The previous-reboot flag is set by `reboot_event`. It is cleared by an authorised halfword write to offset 0xC with data bit 9 or bit 12 set. If both happen in the same cycle, the set wins.
- R6: A halfword read of offset 0xC returns the previous-reboot flag on both bit 9 and bit 12. Every other window read returns 0.
- R7: A halfword write to the setup register (`cfg_sel` = 0) stores three fields: bit 5 as reboot-disable (so `reboot_en` is its inverse), bit 2 as the fast clock-scale select, and bits [1:0] as the interrupt type. `cfg_rdata` returns these bits in the same positions.
- R8: A byte write to the lock register (`cfg_sel` = 1) stores bit 0 as lock, bit 1 as enable and bit 2 as free-run. `cfg_rdata` returns them in those positions. Once lock is set, lock-register writes have no effect until reset.
- R9: A 0x80 key write while armed or open returns the guard to armed. Any other write while armed returns the guard to closed.
- R10: A setup-register write that is not halfword width is ignored. A lock-register write that is not byte width is ignored.
- R11: After reset, the following hold: the guard is closed, the preloads are 0xFFFFF, `reboot_en` is 1, the clock scale is slow, the interrupt type is 0, lock/enable/free-run are 0, and the flag and `kick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_wr | input | 1 | Window write strobe |
| win_rd | input | 1 | Window read strobe |
| win_addr | input | 4 | Window byte offset |
| win_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| win_wdata | input | 32 | Window write data, low-aligned |
| win_rdata | output | 32 | Window read data (combinational) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects setup register, 1 selects lock register |
| cfg_size | input | 2 | Configuration access width, same coding |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected configuration register contents |
| reboot_event | input | 1 | Timer core reports a stage-2 reboot |
| preload1 | output | 20 | Stage-1 preload |
| preload2 | output | 20 | Stage-2 preload |
| kick | output | 1 | One-cycle reload pulse |
| prev_reboot | output | 1 | Previous-reboot flag |
| wd_enable | output | 1 | Watchdog enable |
| wd_free_run | output | 1 | Free-run mode |
| wd_locked | output | 1 | Lock bit |
| reboot_en | output | 1 | Reboot on stage-2 expiry enabled |
| fast_scale | output | 1 | Fast clock-scale select |
| int_type | output | 2 | Stage-1 interrupt type |

## Verification
The bench targets the edges of the key guard. It writes a protected register with no key, and a second protected write after one key pair has been spent; a guard that stayed open would accept the second write. It also sends a repeated 0x80, a stray write between the two key bytes, and a key byte at the wrong offset; a design that handled any of these wrongly would open when it should not. Both clear bits for the flag are tested, and so is a set and clear in the same cycle; a design missing the alternate bit would leave the flag stuck. Writes with the wrong width and writes made after lock are also tried; a design that ignored the width or did not hold the lock would silently change the enable or mode outputs.

// File: rtl/wdt_regfront_pkg.sv
package wdt_regfront_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [1:0] {
      GUARD_CLOSED = 2'd0,
      GUARD_ARMED  = 2'd1,
      GUARD_OPEN   = 2'd2
   } guard_e;

   localparam int WIN_AW = 4;
   localparam logic [WIN_AW-1:0] OFS_PRELOAD1 = 4'h0;
   localparam logic [WIN_AW-1:0] OFS_PRELOAD2 = 4'h4;
   localparam logic [WIN_AW-1:0] OFS_RELOAD   = 4'hC;

endpackage

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
   import wdt_regfront_pkg::*;
#(
   parameter int         DATA_W     = 32,
   parameter logic [7:0] KEY_FIRST  = 8'h80,
   parameter logic [7:0] KEY_SECOND = 8'h86
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WIN_AW-1:0] addr,
   input  logic [DATA_W-1:0] val,
   output logic              grant
);

   guard_e state_q, state_d;
   logic   hit_first, hit_second;

   assign hit_first  = wr && (addr == OFS_RELOAD) && (val == DATA_W'(KEY_FIRST));
   assign hit_second = wr && (addr == OFS_RELOAD) && (val == DATA_W'(KEY_SECOND))
                       && (state_q == GUARD_ARMED);

   always_comb begin
      state_d = state_q;
      if (hit_first)       state_d = GUARD_ARMED;
      else if (hit_second) state_d = GUARD_OPEN;
      else if (wr)         state_d = GUARD_CLOSED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GUARD_CLOSED;
      else        state_q <= state_d;
   end

   assign grant = wr && !hit_first && !hit_second && (state_q == GUARD_OPEN);

   // R1: the guard only opens right after the second key byte
   p_open_after_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == GUARD_OPEN) |->
         $past(wr && addr == OFS_RELOAD && val == DATA_W'(KEY_SECOND)));

   // R2: a granted write always closes the guard
   p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> state_q == GUARD_CLOSED);

endmodule

// File: rtl/wdt_prot_regs.sv
module wdt_prot_regs
   import wdt_regfront_pkg::*;
#(
   parameter int                 DATA_W      = 32,
   parameter int                 PRELOAD_W   = 20,
   parameter logic [PRELOAD_W-1:0] PRELOAD_RST = '1,
   parameter int                 KICK_BIT    = 8,
   parameter int                 FLAG_BIT_A  = 9,
   parameter int                 FLAG_BIT_B  = 12,
   parameter bit                 MIRROR_B    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grant,
   input  logic                 rd,
   input  logic [WIN_AW-1:0]    addr,
   input  logic [1:0]           size,
   input  logic [DATA_W-1:0]    val,
   input  logic                 reboot_event,
   output logic [PRELOAD_W-1:0] preload1,
   output logic [PRELOAD_W-1:0] preload2,
   output logic                 kick,
   output logic                 prev_reboot,
   output logic [DATA_W-1:0]    rdata
);

   logic word_wr, half_reload_wr, clr_hit, status_rd;
   logic [DATA_W-1:0] flag_mask;

   assign word_wr        = grant && (size == ACC_WORD);
   assign half_reload_wr = grant && (size == ACC_HALF) && (addr == OFS_RELOAD);
   assign status_rd      = rd && (size == ACC_HALF) && (addr == OFS_RELOAD);

   generate
      if (MIRROR_B) begin : g_mirror
         assign clr_hit   = val[FLAG_BIT_A] || val[FLAG_BIT_B];
         assign flag_mask = (DATA_W'(1) << FLAG_BIT_A) | (DATA_W'(1) << FLAG_BIT_B);
      end else begin : g_single
         assign clr_hit   = val[FLAG_BIT_A];
         assign flag_mask = DATA_W'(1) << FLAG_BIT_A;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload1 <= PRELOAD_RST;
         preload2 <= PRELOAD_RST;
      end else if (word_wr) begin
         if (addr == OFS_PRELOAD1) preload1 <= val[PRELOAD_W-1:0];
         if (addr == OFS_PRELOAD2) preload2 <= val[PRELOAD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick        <= 1'b0;
         prev_reboot <= 1'b0;
      end else begin
         kick <= half_reload_wr && val[KICK_BIT];
         if (reboot_event)                  prev_reboot <= 1'b1;
         else if (half_reload_wr && clr_hit) prev_reboot <= 1'b0;
      end
   end

   assign rdata = (status_rd && prev_reboot) ? flag_mask : '0;

   // R3: preloads move only on an authorised write
   p_preload_guarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |=> $stable(preload1) && $stable(preload2));

   // R4: a kick never lasts more than one cycle
   p_kick_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !kick);

   // R5: the flag only rises from a reboot report
   p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prev_reboot) |-> $past(reboot_event));

endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
   import wdt_regfront_pkg::*;
#(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_sel,
   input  logic [1:0]       cfg_size,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             reboot_en,
   output logic             fast_scale,
   output logic [1:0]       int_type,
   output logic             wd_enable,
   output logic             wd_free_run,
   output logic             wd_locked
);

   localparam int BIT_NOREBOOT = 5;
   localparam int BIT_FAST     = 2;
   localparam int BIT_LOCK     = 0;
   localparam int BIT_EN       = 1;
   localparam int BIT_FREE     = 2;

   logic setup_wr, lock_wr;
   logic noreboot_q;

   assign setup_wr = cfg_wr && !cfg_sel && (cfg_size == ACC_HALF);
   assign lock_wr  = cfg_wr &&  cfg_sel && (cfg_size == ACC_BYTE) && !wd_locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noreboot_q <= 1'b0;
         fast_scale <= 1'b0;
         int_type   <= 2'd0;
      end else if (setup_wr) begin
         noreboot_q <= cfg_wdata[BIT_NOREBOOT];
         fast_scale <= cfg_wdata[BIT_FAST];
         int_type   <= cfg_wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_locked   <= 1'b0;
         wd_enable   <= 1'b0;
         wd_free_run <= 1'b0;
      end else if (lock_wr) begin
         wd_locked   <= cfg_wdata[BIT_LOCK];
         wd_enable   <= cfg_wdata[BIT_EN];
         wd_free_run <= cfg_wdata[BIT_FREE];
      end
   end

   assign reboot_en = !noreboot_q;

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel) begin
         cfg_rdata[BIT_LOCK] = wd_locked;
         cfg_rdata[BIT_EN]   = wd_enable;
         cfg_rdata[BIT_FREE] = wd_free_run;
      end else begin
         cfg_rdata[BIT_NOREBOOT] = noreboot_q;
         cfg_rdata[BIT_FAST]     = fast_scale;
         cfg_rdata[1:0]          = int_type;
      end
   end

   // R8: lock is one-way and freezes the mode bits
   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_locked |=> wd_locked && $stable(wd_enable) && $stable(wd_free_run));

   // R10: a setup write of the wrong width leaves the setup fields alone
   p_setup_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_sel && cfg_size != ACC_HALF) |=>
         $stable(reboot_en) && $stable(fast_scale) && $stable(int_type));

endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
   import wdt_regfront_pkg::*;
#(
   parameter int         DATA_W     = 32,
   parameter int         PRELOAD_W  = 20,
   parameter int         CFG_W      = 16,
   parameter logic [7:0] KEY_FIRST  = 8'h80,
   parameter logic [7:0] KEY_SECOND = 8'h86,
   parameter bit         MIRROR_B   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 win_wr,
   input  logic                 win_rd,
   input  logic [3:0]           win_addr,
   input  logic [1:0]           win_size,
   input  logic [DATA_W-1:0]    win_wdata,
   output logic [DATA_W-1:0]    win_rdata,
   input  logic                 cfg_wr,
   input  logic                 cfg_sel,
   input  logic [1:0]           cfg_size,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   input  logic                 reboot_event,
   output logic [PRELOAD_W-1:0] preload1,
   output logic [PRELOAD_W-1:0] preload2,
   output logic                 kick,
   output logic                 prev_reboot,
   output logic                 wd_enable,
   output logic                 wd_free_run,
   output logic                 wd_locked,
   output logic                 reboot_en,
   output logic                 fast_scale,
   output logic [1:0]           int_type
);

   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;

   generate
      if (DATA_W < 32 || PRELOAD_W > DATA_W) begin : g_bad_width
         $error("wdt_regfront: DATA_W must be >= 32 and hold PRELOAD_W");
      end
      if (CFG_W < 8) begin : g_bad_cfg
         $error("wdt_regfront: CFG_W must be at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] wval;
   logic              grant;

   always_comb begin
      case (win_size)
         ACC_BYTE: wval = {{(DATA_W-BYTE_W){1'b0}}, win_wdata[BYTE_W-1:0]};
         ACC_HALF: wval = {{(DATA_W-HALF_W){1'b0}}, win_wdata[HALF_W-1:0]};
         default:  wval = win_wdata;
      endcase
   end

   wdt_key_guard #(
      .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .wr(win_wr), .addr(win_addr),
      .val(wval), .grant(grant)
   );

   wdt_prot_regs #(
      .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W), .MIRROR_B(MIRROR_B)
   ) u_prot (
      .clk(clk), .rst_n(rst_n), .grant(grant), .rd(win_rd),
      .addr(win_addr), .size(win_size), .val(wval),
      .reboot_event(reboot_event), .preload1(preload1), .preload2(preload2),
      .kick(kick), .prev_reboot(prev_reboot), .rdata(win_rdata)
   );

   wdt_cfg_regs #(
      .CFG_W(CFG_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .reboot_en(reboot_en), .fast_scale(fast_scale), .int_type(int_type),
      .wd_enable(wd_enable), .wd_free_run(wd_free_run), .wd_locked(wd_locked)
   );

endmodule

// File: tb/wdt_regfront_bench.sv
`timescale 1ns/1ps
module wdt_regfront_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_wr = 0, win_rd = 0;
   logic [3:0]  win_addr = 0;
   logic [1:0]  win_size = 0;
   logic [31:0] win_wdata = 0;
   logic [31:0] win_rdata;
   logic        cfg_wr = 0, cfg_sel = 0;
   logic [1:0]  cfg_size = 0;
   logic [15:0] cfg_wdata = 0;
   logic [15:0] cfg_rdata;
   logic        reboot_event = 0;
   logic [19:0] preload1, preload2;
   logic        kick, prev_reboot, wd_enable, wd_free_run, wd_locked;
   logic        reboot_en, fast_scale;
   logic [1:0]  int_type;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   wdt_regfront u_wdt_regfront (.*);

   // behavioural reference model
   int      m_guard = 0;   // 0 closed, 1 armed, 2 open
   int      m_pl1 = 'hFFFFF, m_pl2 = 'hFFFFF;
   bit      m_kick = 0, m_flag = 0;
   bit      m_nrb = 0, m_fast = 0, m_lock = 0, m_en = 0, m_free = 0;
   int      m_int = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_guard = 0; m_pl1 = 'hFFFFF; m_pl2 = 'hFFFFF; m_kick = 0; m_flag = 0;
         m_nrb = 0; m_fast = 0; m_int = 0; m_lock = 0; m_en = 0; m_free = 0;
      end else begin
         longint v;
         bit clr;
         clr = 0;
         m_kick = 0;
         v = (win_size == 0) ? (win_wdata & 32'hFF) :
             (win_size == 1) ? (win_wdata & 32'hFFFF) : win_wdata;
         if (win_wr) begin
            if (win_addr == 12 && v == 'h80) m_guard = 1;
            else if (win_addr == 12 && v == 'h86 && m_guard == 1) m_guard = 2;
            else begin
               if (m_guard == 2) begin
                  if (win_size == 2 && win_addr == 0) m_pl1 = int'(v % (1 << 20));
                  if (win_size == 2 && win_addr == 4) m_pl2 = int'(v % (1 << 20));
                  if (win_size == 1 && win_addr == 12) begin
                     m_kick = v[8];
                     clr = v[9] | v[12];
                  end
               end
               m_guard = 0;
            end
         end
         if (reboot_event) m_flag = 1;
         else if (clr) m_flag = 0;
         if (cfg_wr && !cfg_sel && cfg_size == 1) begin
            m_nrb = cfg_wdata[5]; m_fast = cfg_wdata[2]; m_int = cfg_wdata[1:0];
         end
         if (cfg_wr && cfg_sel && cfg_size == 0 && !m_lock) begin
            m_lock = cfg_wdata[0]; m_en = cfg_wdata[1]; m_free = cfg_wdata[2];
         end
      end
   end

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every output to the model on each falling edge
   always @(negedge clk) begin
      if (!done) begin
         check("R3 preload1", preload1, m_pl1);
         check("R3 preload2", preload2, m_pl2);
         check("R4 kick", kick, m_kick);
         check("R5 flag", prev_reboot, m_flag);
         check("R6 win_rdata", win_rdata,
               (win_rd && win_size == 1 && win_addr == 12 && m_flag) ? 'h1200 : 0);
         check("R7 setup", {reboot_en, fast_scale, int_type}, {!m_nrb, m_fast, 2'(m_int)});
         check("R8 lock", {wd_locked, wd_enable, wd_free_run}, {m_lock, m_en, m_free});
         check("R7/R8 cfg_rdata", cfg_rdata,
               cfg_sel ? {13'd0, m_free, m_en, m_lock}
                       : {10'd0, m_nrb, 2'd0, m_fast, 2'(m_int)});
      end
   end

   task automatic wwin(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); #1;
      win_wr = 1; win_addr = a; win_size = s; win_wdata = d;
      @(negedge clk); #1;
      win_wr = 0;
   endtask

   task automatic unlock(input logic [1:0] s);
      wwin(4'hC, s, 32'h80);
      wwin(4'hC, s, 32'h86);
   endtask

   task automatic wcfg(input logic sel, input logic [1:0] s, input logic [15:0] d);
      @(negedge clk); #1;
      cfg_wr = 1; cfg_sel = sel; cfg_size = s; cfg_wdata = d;
      @(negedge clk); #1;
      cfg_wr = 0;
   endtask

   task automatic rwin(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp, string req);
      @(negedge clk); #1;
      win_rd = 1; win_addr = a; win_size = s;
      #1 check(req, win_rdata, exp);
      @(negedge clk); #1;
      win_rd = 0;
   endtask

   task automatic pulse_reboot();
      @(negedge clk); #1; reboot_event = 1;
      @(negedge clk); #1; reboot_event = 0;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset values
      check("R11 preload1", preload1, 'hFFFFF);
      check("R11 reboot_en", reboot_en, 1);
      check("R11 lock", {wd_locked, wd_enable, wd_free_run}, 0);
      #1 rst_n = 1;

      // R2: no key, write ignored
      wwin(4'h0, 2, 32'h12345);
      check("R2 unkeyed", preload1, 'hFFFFF);
      // R1/R3: byte key pair then word write, masked to 20 bits
      unlock(0);
      wwin(4'h0, 2, 32'hABC12345);
      check("R3 preload1 load", preload1, 'h12345);
      // R2: key spent, second write ignored
      wwin(4'h4, 2, 32'h55555);
      check("R2 one shot", preload2, 'hFFFFF);
      unlock(1);
      wwin(4'h4, 2, 32'hFFF00001);
      check("R3 preload2 load", preload2, 'h00001);
      // R1: key at wrong offset
      wwin(4'h8, 0, 32'h80);
      wwin(4'hC, 0, 32'h86);
      wwin(4'h0, 2, 32'h777);
      check("R1 wrong offset", preload1, 'h12345);

      // R5/R6: flag and read mirror
      pulse_reboot();
      check("R5 flag set", prev_reboot, 1);
      rwin(4'hC, 1, 32'h1200, "R6 status read");
      rwin(4'hC, 2, 32'h0, "R6 word read zero");
      rwin(4'h0, 1, 32'h0, "R6 other offset zero");
      // R4: kick pulse
      unlock(2);
      wwin(4'hC, 1, 32'h0100);
      check("R4 kick high", kick, 1);
      @(negedge clk); #1;
      check("R4 kick drops", kick, 0);
      check("R4 flag kept", prev_reboot, 1);
      unlock(1);
      wwin(4'hC, 1, 32'h1000);
      check("R5 clear bit12", prev_reboot, 0);
      pulse_reboot();
      unlock(1);
      wwin(4'hC, 1, 32'h0200);
      check("R5 clear bit9", prev_reboot, 0);
      // R5: set wins over clear
      unlock(1);
      @(negedge clk); #1;
      win_wr = 1; win_addr = 4'hC; win_size = 1; win_wdata = 32'h0200; reboot_event = 1;
      @(negedge clk); #1;
      win_wr = 0; reboot_event = 0;
      check("R5 set wins", prev_reboot, 1);

      // R9: repeated first key, stray write, re-arm from open
      wwin(4'hC, 0, 32'h80);
      wwin(4'hC, 0, 32'h80);
      wwin(4'hC, 0, 32'h86);
      wwin(4'h0, 2, 32'h0AAAA);
      check("R9 re-arm", preload1, 'h0AAAA);
      wwin(4'hC, 0, 32'h80);
      wwin(4'h0, 2, 32'h0BBBB);
      wwin(4'hC, 0, 32'h86);
      wwin(4'h0, 2, 32'h0CCCC);
      check("R9 stray closes", preload1, 'h0AAAA);
      unlock(0);
      wwin(4'hC, 0, 32'h80);
      wwin(4'h0, 2, 32'h0DDDD);
      check("R9 open to armed", preload1, 'h0AAAA);

      // R7/R10: setup register
      wcfg(0, 1, 16'h0027);
      check("R7 setup", {reboot_en, fast_scale, int_type}, 4'b0111);
      wcfg(0, 0, 16'h0000);
      check("R10 setup width", int_type, 3);
      wcfg(0, 1, 16'h0001);
      check("R7 setup back", {reboot_en, fast_scale, int_type}, 4'b1001);

      // R8/R10: lock register
      wcfg(1, 1, 16'h0006);
      check("R10 lock width", wd_enable, 0);
      wcfg(1, 0, 16'h0006);
      check("R8 enable free", {wd_locked, wd_enable, wd_free_run}, 3'b011);
      wcfg(1, 0, 16'h0003);
      check("R8 locked", {wd_locked, wd_enable, wd_free_run}, 3'b110);
      wcfg(1, 0, 16'h0004);
      check("R8 frozen", {wd_locked, wd_enable, wd_free_run}, 3'b110);

      // R11: reset clears the lock
      @(negedge clk); #1 rst_n = 0;
      @(negedge clk); #1;
      check("R11 lock cleared", wd_locked, 0);
      check("R11 preload1", preload1, 'hFFFFF);
      rst_n = 1;
      repeat (2) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule